// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a register-mapped controller for up to 32 general-purpose pins. Software reads the synchronised input value of every pin, sets a data-out value and an output enable per pin, and arms interrupts. Each pin can raise a live level interrupt, which has its own polarity and mask, and an edge interrupt, which has a separate polarity, a separate mask and a sticky event bit. Software clears an event bit by writing a 1 to it.

All active level interrupts and all unmasked events are ORed into one summary status bit. A single chip-level enable gates that bit onto the interrupt output. A second register window, selected by a request flag, holds per-pin pad settings: pull-up, pull-down, slew, hysteresis and a three-bit drive-strength code. The code is split across three registers, one bit of the code per register.

The register port is a valid/ready request channel with a registered read response. The block never applies back-pressure: `req_ready` is tied high and a request is accepted in any cycle where `req_valid` is high. Each accepted read returns exactly one `rsp_valid` pulse in the next cycle. The response cannot be stalled, so the requester must take it when it comes. Writes produce no response.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register in both windows reads zero, `pin_oe` is 0, `irq_out` is 0 and all pad outputs are 0.
- R2: `req_ready` is always 1. A read accepted at a clock edge gives `rsp_valid` high for exactly the following cycle, with the data in `rsp_rdata`. Writes never raise `rsp_valid`.
- R3: In the main window, offset 0x44 holds data-out and offset 0x48 holds output enable. `pin_oe` equals the enable register, and pin i drives its data-out bit on `pin_out[i]` only while its enable bit is 1. Otherwise `pin_out[i]` is 0.
- R4: Offset 0x40 is read-only and returns each pin's input after a two-flop synchroniser. A change on `pin_in` is visible to any read issued four or more cycles later.
- R5: Pin i has an active level interrupt when (synchronised input XOR bit i of offset 0x50) AND bit i of offset 0x54 is 1. Polarity 1 selects active-low.
- R6: Event bit i at offset 0x58 is set by a rising synchronised edge when bit i of edge polarity (0x64) is 0, or by a falling edge when it is 1, whatever the event mask. It counts toward the summary only when bit i of offset 0x5C is 1.
- R7: Writing offset 0x58 clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R8: When a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R9: Bit 0 of offset 0x00 is 1 exactly when some pin has an active level interrupt or an unmasked set event bit. Its other bits read 0, and writes to offset 0x00 have no effect.
- R10: `irq_out` is 1 exactly when status bit 0 is 1 and bit 0 of offset 0x04 (chip enable, the only stored bit there) is 1.
- R11: The pad window holds one bit per pin at each of these offsets: drive-code MSB 0x00, middle bit 0x04, LSB 0x08, hysteresis 0x10, slew 0x14, pull-up 0x18 and pull-down 0x1C. Pin i's drive code appears on `pad_drive[3i+2:3i]`, MSB first, and the code stands for (code+1)*2 mA.
- R12: Reads of unmapped offsets in either window return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pad | input | 1 | 1 = pad window, 0 = main window |
| req_addr | input | 8 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Raw pin inputs |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables |
| irq_out | output | 1 | Combined interrupt |
| pad_drive | output | 3*NPINS | Drive code per pin, 3 bits each |
| pad_hyst | output | NPINS | Hysteresis enable |
| pad_slew | output | NPINS | Slew enable |
| pad_pull_up | output | NPINS | Pull-up enable |
| pad_pull_dn | output | NPINS | Pull-down enable |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same clock edge as a new edge event for the same pin. Input changes only reach the event register through the synchroniser and the edge compare. To hit that edge, the stimulus drives the pin on a falling clock edge and starts the clearing write two falling edges later, so the write is accepted on the edge where the event latches. Random pin patterns and random polarity and mask settings are then checked against a bench model of the level terms and the sticky events.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int DRV_W  = 3;

  // main window
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CHIPEN  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_OE      = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_LVL_POL = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_LVL_MSK = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_EVT     = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_EVT_MSK = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_EVT_POL = 8'h64;

  // pad window: drive slices sit at 4*slice, slice 0 holds the MSB
  localparam logic [ADDR_W-1:0] PAD_HYST    = 8'h10;
  localparam logic [ADDR_W-1:0] PAD_SLEW    = 8'h14;
  localparam logic [ADDR_W-1:0] PAD_PU      = 8'h18;
  localparam logic [ADDR_W-1:0] PAD_PD      = 8'h1C;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] din,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= raw[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign din[i]  = s2_q;
    assign rise[i] = s2_q & ~prev_q;
    assign fall[i] = ~s2_q & prev_q;
  end
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  input  logic [NPINS-1:0] lvl_pol,
  input  logic [NPINS-1:0] lvl_msk,
  input  logic [NPINS-1:0] evt_pol,
  input  logic [NPINS-1:0] evt_msk,
  input  logic [NPINS-1:0] evt_clr,
  output logic [NPINS-1:0] evt_q,
  output logic [NPINS-1:0] evt_hit,
  output logic             summary
);
  logic [NPINS-1:0] lvl_act;

  for (genvar i = 0; i < NPINS; i++) begin : g_evt
    assign evt_hit[i] = evt_pol[i] ? fall[i] : rise[i];
    assign lvl_act[i] = (din[i] ^ lvl_pol[i]) & lvl_msk[i];
    // a fresh edge outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          evt_q[i] <= 1'b0;
      else if (evt_hit[i]) evt_q[i] <= 1'b1;
      else if (evt_clr[i]) evt_q[i] <= 1'b0;
    end
  end

  assign summary = |(lvl_act | (evt_q & evt_msk));
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NPINS-1:0]    wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [DRV_W*NPINS-1:0] drive,
  output logic [NPINS-1:0]    hyst,
  output logic [NPINS-1:0]    slew,
  output logic [NPINS-1:0]    pull_up,
  output logic [NPINS-1:0]    pull_dn
);
  logic [NPINS-1:0] drv_q [DRV_W];
  logic [NPINS-1:0] hyst_q, slew_q, pu_q, pd_q;
  logic [DRV_W-1:0] drv_hit;

  for (genvar s = 0; s < DRV_W; s++) begin : g_slice
    assign drv_hit[s] = (addr == ADDR_W'(4 * s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  drv_q[s] <= '0;
      else if (wr_en && drv_hit[s]) drv_q[s] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_q <= '0;
      slew_q <= '0;
      pu_q   <= '0;
      pd_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        PAD_HYST: hyst_q <= wdata;
        PAD_SLEW: slew_q <= wdata;
        PAD_PU:   pu_q   <= wdata;
        PAD_PD:   pd_q   <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_code
    for (genvar s = 0; s < DRV_W; s++) begin : g_bit
      assign drive[DRV_W*i + (DRV_W-1-s)] = drv_q[s][i];
    end
  end

  assign hyst    = hyst_q;
  assign slew    = slew_q;
  assign pull_up = pu_q;
  assign pull_dn = pd_q;

  always_comb begin
    rdata = '0;
    for (int s = 0; s < DRV_W; s++)
      if (drv_hit[s]) rdata[NPINS-1:0] = drv_q[s];
    case (addr)
      PAD_HYST: rdata[NPINS-1:0] = hyst_q;
      PAD_SLEW: rdata[NPINS-1:0] = slew_q;
      PAD_PU:   rdata[NPINS-1:0] = pu_q;
      PAD_PD:   rdata[NPINS-1:0] = pd_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_pad,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic [NPINS-1:0]        pin_in,
  output logic [NPINS-1:0]        pin_out,
  output logic [NPINS-1:0]        pin_oe,
  output logic                    irq_out,
  output logic [DRV_W*NPINS-1:0]  pad_drive,
  output logic [NPINS-1:0]        pad_hyst,
  output logic [NPINS-1:0]        pad_slew,
  output logic [NPINS-1:0]        pad_pull_up,
  output logic [NPINS-1:0]        pad_pull_dn
);
  logic [NPINS-1:0] din, rise, fall;
  logic [NPINS-1:0] dout_q, oe_q, lvl_pol_q, lvl_msk_q, evt_pol_q, evt_msk_q;
  logic [NPINS-1:0] ev_q, ev_hit, ev_clr, wbits;
  logic             chip_en, summary;
  logic             wr_main, wr_pad, rd_req;
  logic [DATA_W-1:0] main_rdata, pad_rdata;

  assign req_ready = 1'b1;
  assign wr_main   = req_valid & req_write & ~req_pad;
  assign wr_pad    = req_valid & req_write & req_pad;
  assign rd_req    = req_valid & ~req_write;
  assign wbits     = req_wdata[NPINS-1:0];
  assign ev_clr    = (wr_main && req_addr == OFS_EVT) ? wbits : '0;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .din(din), .rise(rise), .fall(fall)
  );

  gpio_event_unit #(.NPINS(NPINS)) u_evt (
    .clk(clk), .rst_n(rst_n), .din(din), .rise(rise), .fall(fall),
    .lvl_pol(lvl_pol_q), .lvl_msk(lvl_msk_q), .evt_pol(evt_pol_q),
    .evt_msk(evt_msk_q), .evt_clr(ev_clr), .evt_q(ev_q), .evt_hit(ev_hit),
    .summary(summary)
  );

  gpio_pad_regs #(.NPINS(NPINS)) u_pad (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pad), .addr(req_addr), .wdata(wbits),
    .rdata(pad_rdata), .drive(pad_drive), .hyst(pad_hyst), .slew(pad_slew),
    .pull_up(pad_pull_up), .pull_dn(pad_pull_dn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      oe_q      <= '0;
      lvl_pol_q <= '0;
      lvl_msk_q <= '0;
      evt_pol_q <= '0;
      evt_msk_q <= '0;
      chip_en   <= 1'b0;
    end else if (wr_main) begin
      case (req_addr)
        OFS_CHIPEN:  chip_en   <= req_wdata[0];
        OFS_DOUT:    dout_q    <= wbits;
        OFS_OE:      oe_q      <= wbits;
        OFS_LVL_POL: lvl_pol_q <= wbits;
        OFS_LVL_MSK: lvl_msk_q <= wbits;
        OFS_EVT_MSK: evt_msk_q <= wbits;
        OFS_EVT_POL: evt_pol_q <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    main_rdata = '0;
    case (req_addr)
      OFS_STATUS:  main_rdata[0] = summary;
      OFS_CHIPEN:  main_rdata[0] = chip_en;
      OFS_DIN:     main_rdata[NPINS-1:0] = din;
      OFS_DOUT:    main_rdata[NPINS-1:0] = dout_q;
      OFS_OE:      main_rdata[NPINS-1:0] = oe_q;
      OFS_LVL_POL: main_rdata[NPINS-1:0] = lvl_pol_q;
      OFS_LVL_MSK: main_rdata[NPINS-1:0] = lvl_msk_q;
      OFS_EVT:     main_rdata[NPINS-1:0] = ev_q;
      OFS_EVT_MSK: main_rdata[NPINS-1:0] = evt_msk_q;
      OFS_EVT_POL: main_rdata[NPINS-1:0] = evt_pol_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? (req_pad ? pad_rdata : main_rdata) : '0;
    end
  end

  assign pin_oe  = oe_q;
  assign pin_out = dout_q & oe_q;
  assign irq_out = summary & chip_en;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_pad,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq_out,
  input logic              chip_en,
  input logic [NPINS-1:0]  ev_q,
  input logic [NPINS-1:0]  ev_hit,
  input logic [NPINS-1:0]  ev_clr
);
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R2
  rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R3
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_pad && req_addr == OFS_OE)
    |=> (pin_oe == $past(req_wdata[NPINS-1:0])));
  // R6
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & ~$past(ev_q) & ~$past(ev_hit)) == '0);
  // R7
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_q) & ~$past(ev_clr) & ~ev_q) == '0);
  // R8
  evt_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit != '0) |=> ((ev_q & $past(ev_hit)) == $past(ev_hit)));
  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> chip_en);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_pad(req_pad), .req_addr(req_addr),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .pin_oe(pin_oe),
  .irq_out(irq_out), .chip_en(chip_en), .ev_q(ev_q), .ev_hit(ev_hit),
  .ev_clr(ev_clr)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_pad = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, irq_out;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pad_hyst, pad_slew, pad_pull_up, pad_pull_dn;
  logic [3*NP-1:0] pad_drive;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_pad(req_pad), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out),
    .pad_drive(pad_drive), .pad_hyst(pad_hyst), .pad_slew(pad_slew),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic pad, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_pad = pad; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic pad, input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_pad = pad; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    v = rsp_valid;
  endtask

  task automatic rd_chk(input string rq, input logic pad, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    rd(pad, a, d, v);
    check(rq, d, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic lvl_status(logic [31:0] pins, logic [31:0] pol, logic [31:0] msk);
    return |((pins ^ pol) & msk);
  endfunction

  function automatic logic [31:0] new_events(logic [31:0] oldp, logic [31:0] newp, logic [31:0] pol);
    return (pol & oldp & ~newp) | (~pol & ~oldp & newp);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pol, msk, evp, evm, ev_exp, oldp, w, wb [7];
    logic v, st;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pad_drive", pad_drive[31:0] | pad_drive[63:32] | pad_drive[95:64], 0);
    rd_chk("R1 dout", 0, 8'h44, 0);
    rd_chk("R1 events", 0, 8'h58, 0);
    rd_chk("R1 status", 0, 8'h00, 0);
    rd_chk("R1 pad pull-up", 1, 8'h18, 0);

    // R2 handshake
    check("R2 req_ready", {31'b0, req_ready}, 1);
    rd(0, 8'h48, d, v);
    check("R2 rsp_valid after read", {31'b0, v}, 1);
    @(negedge clk);
    check("R2 rsp_valid one cycle", {31'b0, rsp_valid}, 0);
    wr(0, 8'h44, 32'h0);
    check("R2 no rsp on write", {31'b0, rsp_valid}, 0);

    // R3 data-out / enable
    wr(0, 8'h44, 32'hF0F0_1234);
    wr(0, 8'h48, 32'h00FF_00FF);
    check("R3 pin_oe", pin_oe, 32'h00FF_00FF);
    check("R3 pin_out gated", pin_out, 32'hF0F0_1234 & 32'h00FF_00FF);
    rd_chk("R3 dout readback", 0, 8'h44, 32'hF0F0_1234);

    // R12 unmapped offsets
    wr(0, 8'h4C, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped main read", 0, 8'h4C, 0);
    rd_chk("R12 unmapped write no effect", 0, 8'h48, 32'h00FF_00FF);
    rd_chk("R12 unmapped pad 0x0C", 1, 8'h0C, 0);
    rd_chk("R12 unmapped pad 0x20", 1, 8'h20, 0);

    // R4 input readback
    for (int k = 0; k < 10; k++) begin
      pin_in = $urandom;
      settle();
      rd_chk("R4 data-in", 0, 8'h40, pin_in);
    end

    // R5 / R10 directed level case
    wr(0, 8'h58, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0008;
    settle();
    wr(0, 8'h58, 32'hFFFF_FFFF);
    wr(0, 8'h50, 32'h0);
    wr(0, 8'h54, 32'h0000_0008);
    rd_chk("R5 active-high level", 0, 8'h00, 1);
    check("R10 irq blocked by chip enable", {31'b0, irq_out}, 0);
    wr(0, 8'h04, 32'hFFFF_FFFF);
    check("R10 irq with chip enable", {31'b0, irq_out}, 1);
    rd_chk("R10 chip enable stores bit 0 only", 0, 8'h04, 1);
    wr(0, 8'h50, 32'h0000_0008);
    rd_chk("R5 polarity 1 is active-low", 0, 8'h00, 0);
    check("R10 irq drops", {31'b0, irq_out}, 0);
    // R9 write to status ignored
    wr(0, 8'h00, 32'hFFFF_FFFF);
    rd_chk("R9 status read-only", 0, 8'h00, 0);

    // R5 / R9 / R10 random level patterns, events masked
    wr(0, 8'h5C, 32'h0);
    for (int k = 0; k < 30; k++) begin
      pol = $urandom; msk = $urandom;
      if (k % 3 == 0) msk = msk & (msk >> 7) & (msk >> 13);
      pin_in = $urandom;
      wr(0, 8'h50, pol);
      wr(0, 8'h54, msk);
      settle();
      st = lvl_status(pin_in, pol, msk);
      rd_chk("R9 status from levels", 0, 8'h00, {31'b0, st});
      check("R10 irq_out level", {31'b0, irq_out}, {31'b0, st});
    end

    // R6 / R7 random edges, levels masked
    wr(0, 8'h54, 32'h0);
    wr(0, 8'h58, 32'hFFFF_FFFF);
    ev_exp = 0;
    for (int k = 0; k < 30; k++) begin
      evp = $urandom; evm = $urandom;
      if (k % 4 == 0) evm = 0;
      wr(0, 8'h64, evp);
      wr(0, 8'h5C, evm);
      oldp = pin_in;
      pin_in = $urandom;
      settle();
      ev_exp = ev_exp | new_events(oldp, pin_in, evp);
      rd_chk("R6 event latch", 0, 8'h58, ev_exp);
      rd_chk("R6 event mask to status", 0, 8'h00, {31'b0, |(ev_exp & evm)});
      w = $urandom;
      wr(0, 8'h58, w);
      ev_exp = ev_exp & ~w;
      rd_chk("R7 write-one-to-clear", 0, 8'h58, ev_exp);
    end

    // R8 edge and clear in the same cycle
    wr(0, 8'h64, 32'h0);
    pin_in = 32'h0;
    settle();
    pin_in = 32'h1;
    settle();
    wr(0, 8'h58, 32'hFFFF_FFFE);
    rd_chk("R8 precondition event set", 0, 8'h58, 32'h1);
    pin_in = 32'h0;
    settle();
    @(negedge clk);
    pin_in = 32'h1;
    @(negedge clk);
    wr(0, 8'h58, 32'h1);
    rd_chk("R8 new edge beats clear", 0, 8'h58, 32'h1);
    wr(0, 8'h58, 32'h1);
    rd_chk("R7 clear afterwards", 0, 8'h58, 32'h0);

    // R11 pad window
    wr(1, 8'h00, 32'h0000_0020);
    wr(1, 8'h04, 32'h0);
    wr(1, 8'h08, 32'h0000_0020);
    check("R11 drive code pin5 MSB first", {29'b0, pad_drive[17:15]}, 32'd5);
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < 7; r++) begin
        wb[r] = $urandom;
        wr(1, (r < 3) ? 8'(4 * r) : 8'(8'h10 + 4 * (r - 3)), wb[r]);
      end
      for (int r = 0; r < 7; r++)
        rd_chk("R11 pad readback", 1, (r < 3) ? 8'(4 * r) : 8'(8'h10 + 4 * (r - 3)), wb[r]);
      check("R11 hysteresis", pad_hyst, wb[3]);
      check("R11 slew", pad_slew, wb[4]);
      check("R11 pull-up", pad_pull_up, wb[5]);
      check("R11 pull-down", pad_pull_dn, wb[6]);
      for (int i = 0; i < NP; i += 7)
        check("R11 drive code", {29'b0, pad_drive[3*i +: 3]}, {29'b0, wb[0][i], wb[1][i], wb[2][i]});
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule